// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that runs work lists held in memory. Each list entry is a four-word descriptor. Software loads the address of the first descriptor, rings a doorbell and sets the enable flag. The channel then reads the descriptor and moves the block it describes from a source address to a target address. The block is counted in transfer units whose size is picked by the descriptor. After that the channel either follows a link to the next descriptor or stops and flags completion.

Every descriptor is found at the base address plus a 16-byte-granular offset, which the previous entry carries in the top byte of its count word. A zero offset leads back to the base, so a chain can close into a ring for cyclic buffers. An interrupt is possible only at the end of a descriptor whose link flag is clear, never in the middle of a chain. A single word-wide request/acknowledge memory port serves both descriptor fetches and data beats. A peripheral request input paces units for device transfers.

Top module: `dmac_chan`

## Requirements
- R1: After reset the status register reads 0, the count register reads 0, irq is low and no memory request is made.
- R2: After software writes the base (register 0), pulses doorbell and writes 1 to status (register 2), the channel reads four words from the descriptor address in ascending order: command, source address, target address, count. It holds each request steady until it is acknowledged.
- R3: Command bits 10:8 give the unit size: code 0 is 4 bytes, 1 is 1, 2 is 2, 3 is 16, 4 is 32, 5 is 64 and 6 is 128. Bits 23:0 of the count word give the number of units. Units of 4 bytes or more move as whole 32-bit words.
- R4: Command bit 23 makes the source address advance after each beat and bit 22 does the same for the target address. With the bit clear, that address stays fixed.
- R5: 1-byte and 2-byte units write only the addressed byte lanes (mem_be) and carry the source bytes over to the target lanes.
- R6: With command bit 0 (link) set, the channel fetches the next descriptor from base + 16 × count-word bits 31:24 once the count is spent.
- R7: A linked descriptor with offset 0 sends the channel back to the base descriptor, so the chain runs as a ring until software stops it.
- R8: When a descriptor with link clear ends, the channel sets status bit 3, clears status bit 0 and goes idle. irq is then high exactly if that descriptor had command bit 1 set. No irq is raised while a chain is still running.
- R9: If the source or target address is not a multiple of the unit size, or the size code is 7, the channel sets status bits 4 and 2, clears bit 0 and moves no data.
- R10: Unless command bit 31 is set, each unit waits for preq to be high before its first read.
- R11: Writing 0 to a status flag clears it. Writing 0 to bit 0 stops the channel on the next cycle. irq falls when bit 3 is cleared.
- R12: The count register (register 1) shows the units that remain in the active descriptor.
- R13: A descriptor with a count of zero completes with no data beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 count, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| doorbell | input | 1 | One-cycle pulse that arms a descriptor fetch |
| preq | input | 1 | Peripheral request, paces units |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A register write takes effect at the next rising edge and can be read back in the following cycle. A stop through the status register drops mem_req one cycle after the write. Every other result waits on memory handshakes. With the bench's responder each access takes two cycles, so a single-word descriptor ends roughly a dozen cycles after the enable write. The bench therefore never samples at a fixed cycle for these results. It polls the status register at the falling edge under a bounded limit, and checks memory contents, write-beat counts and the logged fetch addresses once the enable bit has fallen, or at the first cycle irq is seen.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_WAITP,
    S_RD,
    S_WR
  } seq_state_e;

  // command word bit positions
  localparam int CMD_LINK = 0;
  localparam int CMD_TIE  = 1;
  localparam int CMD_SZ   = 8;
  localparam int CMD_DINC = 22;
  localparam int CMD_SINC = 23;
  localparam int CMD_AUTO = 31;

  // status register bit positions
  localparam int ST_EN   = 0;
  localparam int ST_HALT = 2;
  localparam int ST_TT   = 3;
  localparam int ST_AR   = 4;

  // register selects
  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  // largest unit is 2**MAX_LG bytes, moved in 4-byte beats
  localparam int MAX_LG = 7;
  localparam int BEAT_W = MAX_LG - 2;
  localparam int DESC_LG = 4;

endpackage

// File: rtl/dmac_size_dec.sv
module dmac_size_dec
  import dmac_pkg::*;
(
  input  logic [2:0]        size_code,
  output logic [2:0]        size_lg,
  output logic              size_bad,
  output logic [BEAT_W-1:0] beats_m1,
  output logic [7:0]        unit_mask
);

  always_comb begin
    size_bad = 1'b0;
    case (size_code)
      3'd0:    size_lg = 3'd2;
      3'd1:    size_lg = 3'd0;
      3'd2:    size_lg = 3'd1;
      3'd3:    size_lg = 3'd4;
      3'd4:    size_lg = 3'd5;
      3'd5:    size_lg = 3'd6;
      3'd6:    size_lg = 3'd7;
      default: begin
        size_lg  = 3'd0;
        size_bad = 1'b1;
      end
    endcase
    if (size_lg >= 3'd2) beats_m1 = BEAT_W'((32'd1 << (size_lg - 3'd2)) - 32'd1);
    else                 beats_m1 = '0;
    unit_mask = 8'((9'd1 << size_lg) - 9'd1);
  end

endmodule

// File: rtl/dmac_lane.sv
module dmac_lane (
  input  logic [1:0]  src_lo,
  input  logic [1:0]  dst_lo,
  input  logic [2:0]  size_lg,
  input  logic [31:0] rd_word,
  output logic [3:0]  wr_be,
  output logic [31:0] wr_word,
  output logic [2:0]  step
);

  logic [1:0]  shift_b;
  logic [5:0]  amt;
  logic [63:0] dbl;

  always_comb begin
    shift_b = dst_lo - src_lo;
    amt     = 6'd32 - {1'b0, shift_b, 3'b000};
    dbl     = {rd_word, rd_word};
    wr_word = 32'(dbl >> amt);
    case (size_lg)
      3'd0: begin
        wr_be = 4'b0001 << dst_lo;
        step  = 3'd1;
      end
      3'd1: begin
        wr_be = 4'b0011 << dst_lo;
        step  = 3'd2;
      end
      default: begin
        wr_be = 4'hF;
        step  = 3'd4;
      end
    endcase
  end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int OFF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              doorbell,
  input  logic              preq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              irq,
  output logic [2:0]        size_code,
  input  logic              size_bad,
  input  logic [BEAT_W-1:0] beats_m1,
  input  logic [7:0]        unit_mask,
  output logic [1:0]        src_lo,
  output logic [1:0]        dst_lo,
  output logic [31:0]       rd_buf,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_word,
  input  logic [2:0]        step,
  output logic              st_en,
  output logic              st_halt,
  output logic              st_tt,
  output logic              st_ar
);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     base_q, base_d, cur_q, cur_d, src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [1:0]        widx_q, widx_d;
  logic [31:0]       rbuf_q, rbuf_d;
  logic [2:0]        sz_q, sz_d;
  logic              link_q, link_d, tie_q, tie_d, sinc_q, sinc_d, dinc_q, dinc_d;
  logic              auto_q, auto_d, endtie_q, endtie_d;
  logic              en_q, en_d, halt_q, halt_d, tt_q, tt_d, ar_q, ar_d, pend_q, pend_d;
  logic              desc_end, misaligned;

  assign misaligned = |((src_q[7:0] | dst_q[7:0]) & unit_mask);

  always_comb begin
    state_d = state_q; base_d = base_q; cur_d = cur_q; src_d = src_q; dst_d = dst_q;
    cnt_d = cnt_q; off_d = off_q; beat_d = beat_q; widx_d = widx_q; rbuf_d = rbuf_q;
    sz_d = sz_q; link_d = link_q; tie_d = tie_q; sinc_d = sinc_q; dinc_d = dinc_q;
    auto_d = auto_q; endtie_d = endtie_q; en_d = en_q; halt_d = halt_q; tt_d = tt_q;
    ar_d = ar_q; pend_d = pend_q;
    desc_end  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'hF;
    mem_wdata = '0;

    case (state_q)
      S_IDLE: begin
        if (en_q && pend_q && !halt_q && !ar_q) begin
          cur_d   = base_q;
          widx_d  = '0;
          pend_d  = 1'b0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'({widx_q, 2'b00});
        if (mem_ack) begin
          widx_d = widx_q + 2'd1;
          case (widx_q)
            2'd0: begin
              link_d = mem_rdata[CMD_LINK];
              tie_d  = mem_rdata[CMD_TIE];
              sz_d   = mem_rdata[CMD_SZ +: 3];
              dinc_d = mem_rdata[CMD_DINC];
              sinc_d = mem_rdata[CMD_SINC];
              auto_d = mem_rdata[CMD_AUTO];
            end
            2'd1: src_d = mem_rdata[AW-1:0];
            2'd2: dst_d = mem_rdata[AW-1:0];
            default: begin
              cnt_d   = mem_rdata[CNT_W-1:0];
              off_d   = mem_rdata[31 -: OFF_W];
              state_d = S_CHECK;
            end
          endcase
        end
      end
      S_CHECK: begin
        if (size_bad || misaligned) begin
          ar_d    = 1'b1;
          halt_d  = 1'b1;
          en_d    = 1'b0;
          state_d = S_IDLE;
        end else if (cnt_q == '0) begin
          desc_end = 1'b1;
        end else begin
          beat_d  = beats_m1;
          state_d = auto_q ? S_RD : S_WAITP;
        end
      end
      S_WAITP: begin
        if (preq) state_d = S_RD;
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = {src_q[AW-1:2], 2'b00};
        if (mem_ack) begin
          rbuf_d  = mem_rdata;
          state_d = S_WR;
        end
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {dst_q[AW-1:2], 2'b00};
        mem_be    = wr_be;
        mem_wdata = wr_word;
        if (mem_ack) begin
          if (sinc_q) src_d = src_q + AW'(step);
          if (dinc_q) dst_d = dst_q + AW'(step);
          if (beat_q == '0) begin
            cnt_d = cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
              desc_end = 1'b1;
            end else begin
              beat_d  = beats_m1;
              state_d = auto_q ? S_RD : S_WAITP;
            end
          end else begin
            beat_d  = beat_q - BEAT_W'(1);
            state_d = S_RD;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (desc_end) begin
      if (link_q) begin
        cur_d   = base_q + (AW'(off_q) << DESC_LG);
        widx_d  = '0;
        state_d = S_FETCH;
      end else begin
        tt_d     = 1'b1;
        en_d     = 1'b0;
        endtie_d = tie_q;
        state_d  = S_IDLE;
      end
    end

    if (doorbell) pend_d = 1'b1;

    if (reg_wr) begin
      case (reg_addr)
        REG_BASE: base_d = reg_wdata[AW-1:0];
        REG_STAT: begin
          en_d   = reg_wdata[ST_EN];
          halt_d = halt_q & reg_wdata[ST_HALT];
          tt_d   = tt_q & reg_wdata[ST_TT];
          ar_d   = ar_q & reg_wdata[ST_AR];
          if (!reg_wdata[ST_EN]) state_d = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; base_q <= '0; cur_q <= '0; src_q <= '0; dst_q <= '0;
      cnt_q <= '0; off_q <= '0; beat_q <= '0; widx_q <= '0; rbuf_q <= '0;
      sz_q <= '0; link_q <= 1'b0; tie_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      auto_q <= 1'b0; endtie_q <= 1'b0; en_q <= 1'b0; halt_q <= 1'b0;
      tt_q <= 1'b0; ar_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      state_q <= state_d; base_q <= base_d; cur_q <= cur_d; src_q <= src_d; dst_q <= dst_d;
      cnt_q <= cnt_d; off_q <= off_d; beat_q <= beat_d; widx_q <= widx_d; rbuf_q <= rbuf_d;
      sz_q <= sz_d; link_q <= link_d; tie_q <= tie_d; sinc_q <= sinc_d; dinc_q <= dinc_d;
      auto_q <= auto_d; endtie_q <= endtie_d; en_q <= en_d; halt_q <= halt_d;
      tt_q <= tt_d; ar_q <= ar_d; pend_q <= pend_d;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_BASE: reg_rdata = 32'(base_q);
      REG_CNT:  reg_rdata = 32'(cnt_q);
      REG_STAT: reg_rdata = {27'd0, ar_q, tt_q, halt_q, 1'b0, en_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq       = tt_q & endtie_q;
  assign size_code = sz_q;
  assign src_lo    = src_q[1:0];
  assign dst_lo    = dst_q[1:0];
  assign rd_buf    = rbuf_q;
  assign st_en     = en_q;
  assign st_halt   = halt_q;
  assign st_tt     = tt_q;
  assign st_ar     = ar_q;

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int OFF_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          doorbell,
  input  logic          preq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          irq
);

  logic [2:0]        size_code, size_lg, step;
  logic              size_bad;
  logic [BEAT_W-1:0] beats_m1;
  logic [7:0]        unit_mask;
  logic [1:0]        src_lo, dst_lo;
  logic [31:0]       rd_buf, wr_word;
  logic [3:0]        wr_be;
  logic              st_en, st_halt, st_tt, st_ar;

  dmac_size_dec u_size (
    .size_code (size_code),
    .size_lg   (size_lg),
    .size_bad  (size_bad),
    .beats_m1  (beats_m1),
    .unit_mask (unit_mask)
  );

  dmac_lane u_lane (
    .src_lo  (src_lo),
    .dst_lo  (dst_lo),
    .size_lg (size_lg),
    .rd_word (rd_buf),
    .wr_be   (wr_be),
    .wr_word (wr_word),
    .step    (step)
  );

  dmac_seq #(.AW(AW), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .doorbell  (doorbell),
    .preq      (preq),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .irq       (irq),
    .size_code (size_code),
    .size_bad  (size_bad),
    .beats_m1  (beats_m1),
    .unit_mask (unit_mask),
    .src_lo    (src_lo),
    .dst_lo    (dst_lo),
    .rd_buf    (rd_buf),
    .wr_be     (wr_be),
    .wr_word   (wr_word),
    .step      (step),
    .st_en     (st_en),
    .st_halt   (st_halt),
    .st_tt     (st_tt),
    .st_ar     (st_ar)
  );

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          wdata_en,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          mem_ack,
  input logic          st_en,
  input logic          st_halt,
  input logic          st_tt,
  input logic          st_ar
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !(reg_wr && reg_addr == 2'd2))
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                             || $countones(mem_be) == 4));

  // R8
  tt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tt) |-> (!mem_req && !st_en));

  // R9
  ar_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ar |-> !mem_we);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_halt |-> !mem_req);

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !wdata_en) |=> !mem_req);

endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .wdata_en (reg_wdata[0]),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_ack  (mem_ack),
  .st_en    (st_en),
  .st_halt  (st_halt),
  .st_tt    (st_tt),
  .st_ar    (st_ar)
);

// File: tb/tb_dmac_chan.sv
`timescale 1ns/1ps
module tb_dmac_chan;

  logic        clk, rst_n;
  logic        reg_wr, doorbell, preq;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:255];
  logic        tb_we;
  logic [7:0]  tb_idx;
  logic [31:0] tb_data;
  logic [31:0] rd_log [0:255];
  int          rd_n, wr_n;
  int          total, bad;

  localparam logic [31:0] C_LINK = 32'h1;
  localparam logic [31:0] C_TIE  = 32'h2;
  localparam logic [31:0] C_DINC = 32'h1 << 22;
  localparam logic [31:0] C_SINC = 32'h1 << 23;
  localparam logic [31:0] C_AUTO = 32'h1 << 31;

  dmac_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .doorbell(doorbell),
    .preq(preq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory responder: one acknowledge per request, one cycle after it appears
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      rd_n      <= 0;
      wr_n      <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (tb_we) mem[tb_idx] = tb_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
          wr_n <= wr_n + 1;
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
          rd_log[rd_n[7:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    tb_idx = addr[9:2]; tb_data = data; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic start(input logic [31:0] base);
    reg_write(2'd0, base);
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
    reg_write(2'd2, 32'h1);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd2, s);
      if (!s[0]) return;
    end
    chk({req, " timeout"}, s, 32'h0);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] cmd,
                          input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cw);
    poke(a, cmd); poke(a + 4, src); poke(a + 8, dst); poke(a + 12, cw);
  endtask

  task automatic fill_src();
    for (int i = 0; i < 16; i++) poke(32'h200 + 32'(i * 4), 32'hA000_0000 + 32'(i));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd2, v); chk("R1 status", v, 32'h0);
    reg_read(2'd1, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
  endtask

  task automatic t_copy();
    logic [31:0] v;
    int n0;
    fill_src();
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | C_TIE, 32'h200, 32'h300, 32'd4);
    n0 = rd_n;
    start(32'h100);
    wait_done("R8 copy");
    for (int i = 0; i < 4; i++) chk("R3 word copy", mem[8'hC0 + 8'(i)], 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) chk("R2 fetch order", rd_log[8'(n0 + i)], 32'h100 + 32'(i * 4));
    reg_read(2'd2, v); chk("R8 status after end", v, 32'h8);
    chk("R8 irq with tie", {31'd0, irq}, 32'h1);
    reg_read(2'd1, v); chk("R12 count spent", v, 32'h0);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R11 status cleared", v, 32'h0);
    chk("R11 irq cleared", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_burst();
    int w0;
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | (32'd3 << 8), 32'h200, 32'h380, 32'd2);
    w0 = wr_n;
    start(32'h100);
    wait_done("R3 burst");
    for (int i = 0; i < 8; i++) chk("R3 16-byte units", mem[8'hE0 + 8'(i)], 32'hA000_0000 + 32'(i));
    chk("R3 beat count", 32'(wr_n - w0), 32'd8);
    chk("R8 no irq without tie", {31'd0, irq}, 32'h0);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_bytes();
    int w0;
    poke(32'h200, 32'h4433_2211);
    poke(32'h340, 32'h0); poke(32'h344, 32'h0); poke(32'h348, 32'h0);
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | (32'd1 << 8), 32'h200, 32'h343, 32'd3);
    w0 = wr_n;
    start(32'h100);
    wait_done("R5 bytes");
    chk("R5 byte lane 3", mem[8'hD0], 32'h1100_0000);
    chk("R5 byte lanes 0-1", mem[8'hD1], 32'h0000_3322);
    chk("R5 byte beats", 32'(wr_n - w0), 32'd3);
    reg_write(2'd2, 32'h0);
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | (32'd2 << 8), 32'h202, 32'h348, 32'd1);
    start(32'h100);
    wait_done("R5 half");
    chk("R5 halfword lanes", mem[8'hD2], 32'h0000_4433);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_preq();
    logic [31:0] v;
    int w0;
    fill_src();
    put_desc(32'h100, C_DINC | C_TIE, 32'h204, 32'h3A0, 32'd3);
    w0 = wr_n;
    start(32'h100);
    repeat (60) @(negedge clk);
    chk("R10 no beats without preq", 32'(wr_n - w0), 32'd0);
    reg_read(2'd1, v); chk("R12 count while waiting", v, 32'd3);
    reg_read(2'd2, v); chk("R10 still enabled", v, 32'h1);
    preq = 1'b1;
    wait_done("R10 preq");
    preq = 1'b0;
    for (int i = 0; i < 3; i++) chk("R4 fixed source", mem[8'hE8 + 8'(i)], 32'hA000_0001);
    reg_read(2'd2, v); chk("R8 status", v, 32'h8);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_chain();
    int n0;
    logic seen;
    poke(32'h3C0, 32'h0); poke(32'h3C4, 32'h0);
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | C_TIE | C_LINK, 32'h200, 32'h3C0,
             (32'd2 << 24) | 32'd1);
    put_desc(32'h120, C_AUTO | C_SINC | C_DINC | C_TIE, 32'h208, 32'h3C4, 32'd1);
    n0 = rd_n;
    start(32'h100);
    seen = 1'b0;
    for (int i = 0; i < 500 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk("R8 irq at chain end", {31'd0, seen}, 32'h1);
    chk("R8 first link done at irq", mem[8'hF0], 32'hA000_0000);
    chk("R8 second link done at irq", mem[8'hF1], 32'hA000_0002);
    chk("R6 next descriptor address", rd_log[8'(n0 + 5)], 32'h120);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_ring();
    logic [31:0] v;
    int n0, w0;
    put_desc(32'h140, C_AUTO | C_LINK, 32'h200, 32'h3E0, (32'd1 << 24) | 32'd1);
    put_desc(32'h150, C_AUTO | C_LINK, 32'h204, 32'h3E4, 32'd1);
    n0 = rd_n;
    start(32'h140);
    repeat (80) @(negedge clk);
    chk("R7 second descriptor", rd_log[8'(n0 + 5)], 32'h150);
    chk("R7 wrap to base", rd_log[8'(n0 + 10)], 32'h140);
    reg_read(2'd2, v); chk("R7 ring still running", v, 32'h1);
    reg_write(2'd2, 32'h0);
    chk("R11 stop drops request", {31'd0, mem_req}, 32'h0);
    w0 = wr_n;
    repeat (20) @(negedge clk);
    chk("R11 no beats after stop", 32'(wr_n - w0), 32'd0);
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    int w0;
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | C_TIE | (32'd3 << 8), 32'h204, 32'h300, 32'd1);
    w0 = wr_n;
    start(32'h100);
    wait_done("R9 misalign");
    reg_read(2'd2, v); chk("R9 error flags", v, 32'h14);
    chk("R9 no data moved", 32'(wr_n - w0), 32'd0);
    chk("R9 no irq", {31'd0, irq}, 32'h0);
    reg_write(2'd2, 32'h0);
    put_desc(32'h100, C_AUTO | C_SINC | C_DINC | (32'd7 << 8), 32'h200, 32'h300, 32'd1);
    start(32'h100);
    wait_done("R9 bad size");
    reg_read(2'd2, v); chk("R9 size code 7", v, 32'h14);
    chk("R9 size code 7 no data", 32'(wr_n - w0), 32'd0);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R11 error flags cleared", v, 32'h0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int w0;
    put_desc(32'h100, C_AUTO | C_TIE, 32'h200, 32'h300, 32'd0);
    w0 = wr_n;
    start(32'h100);
    wait_done("R13 zero");
    reg_read(2'd2, v); chk("R13 completes", v, 32'h8);
    chk("R13 irq", {31'd0, irq}, 32'h1);
    chk("R13 no beats", 32'(wr_n - w0), 32'd0);
    reg_write(2'd2, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    doorbell = 1'b0; preq = 1'b0; tb_we = 1'b0; tb_idx = '0; tb_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_copy();
    t_burst();
    t_bytes();
    t_preq();
    t_chain();
    t_ring();
    t_misalign();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule